// File: doc/BRIEF.md
# Control-Transfer Resolver

This block settles the outcome of one decoded control-transfer instruction of a 16-bit segmented processor. Each input beat carries the opcode byte, up to four operand bytes that followed it, the current instruction pointer, code segment and count register, and the five arithmetic flags. The block decides whether control moves. It produces the next instruction pointer and code segment, and says whether the count register must be rewritten and with what value. Instruction fetch, targets read from memory and stack work belong to other blocks.

Both sides are valid/ready streams. An input beat is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result appears registered on the next cycle with `out_valid` high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. While a result waits (`out_valid` high, `out_ready` low), the block holds every result port unchanged and drops `in_ready`. A new beat can be taken in the same cycle that the waiting result is consumed. Flags are plain inputs that are sampled with the beat.

Top module: `ctl_xfer_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: An accepted beat gives `out_valid` on the next cycle. `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, every result port holds its value.
- R3: Opcode 0xEB is always taken. The next IP is IP+2 plus `in_imm[7:0]`, which is sign-extended.
- R4: Opcode 0xE9 is always taken. The next IP is IP+3 plus the signed word `in_imm[15:0]` (low byte in bits 7:0), modulo 2^16. CS is kept.
- R5: Opcode 0xEA is always taken. The next IP is `in_imm[15:0]` and the next CS is `in_imm[31:16]`.
- R6: For opcodes 0x70–0x7F, the taken decision is as follows. An even opcode tests a condition and the next odd opcode tests its negation. The base conditions, in order, are: 70 O=1, 72 C=1, 74 Z=1, 76 C|Z, 78 S=1, 7A P=1, 7C S≠O, 7E Z|(S≠O).
- R7: A conditional jump (0x70–0x7F) that is taken goes to IP+2+sext(`in_imm[7:0]`). One that is not taken goes to IP+2.
- R8: Opcode 0xE3 is taken exactly when CX is 0. It never requests a CX write. Its target and fall-through follow R7.
- R9: Opcode 0xE2 always writes CX−1, modulo 2^16. It is taken when that value is nonzero. Its target and fall-through follow R7.
- R10: Opcode 0xE1 writes CX−1 and is taken when that value is nonzero and Z=1. Opcode 0xE0 does the same, with Z=0. CX is written even when the jump is not taken.
- R11: Any other opcode gives taken=0, next IP equal to the input IP, the CS unchanged and no CX write.
- R12: Every opcode other than 0xEA leaves CS unchanged. Only 0xE0–0xE2 set `out_cx_we`. When `out_cx_we` is 0, `out_cx` equals the input CX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can accept a beat |
| in_op | input | 8 | Opcode byte |
| in_imm | input | 32 | Operand bytes, first byte in bits 7:0 |
| in_ip | input | 16 | IP of the instruction |
| in_cs | input | 16 | Current code segment |
| in_cx | input | 16 | Current count register |
| flag_c | input | 1 | Carry flag |
| flag_p | input | 1 | Parity flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_o | input | 1 | Overflow flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_taken | output | 1 | Transfer taken |
| out_ip | output | 16 | Next IP |
| out_cs | output | 16 | Next CS |
| out_cx_we | output | 1 | CX must be rewritten |
| out_cx | output | 16 | New CX value |

## Verification
The assertions check the stream rules on every cycle: a result follows each accepted beat, and results are held under back-pressure. They also check, for every beat, that CS survives all opcodes but the far jump, that the far jump loads its immediate, that the loop forms write CX−1, and that the CX-zero test leaves CX alone and decides on CX alone. The flag decoding of all sixteen conditional forms cannot be shown by these properties, and neither can the address wrap on relative jumps or the mix of the loop-count and zero-flag tests. These are shown only by the bench scenarios. Each scenario compares every result with the bench's own model under random back-pressure.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [2:0] {
    K_NONE,
    K_JCC,
    K_SHORT,
    K_NEAR,
    K_FAR,
    K_JCXZ,
    K_LOOP
  } kind_t;

  typedef enum logic [1:0] {
    LM_PLAIN,
    LM_ZSET,
    LM_ZCLR
  } loop_mode_t;

  typedef struct packed {
    logic o;
    logic s;
    logic z;
    logic p;
    logic c;
  } flags_t;
endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
  import xfer_pkg::*;
(
  input  logic [7:0]  op,
  output kind_t       kind,
  output logic [2:0]  len,
  output loop_mode_t  lmode
);
  always_comb begin
    kind  = K_NONE;
    len   = 3'd0;
    lmode = LM_PLAIN;
    if (op[7:4] == 4'h7) begin
      kind = K_JCC;
      len  = 3'd2;
    end else begin
      case (op)
        8'hEB: begin kind = K_SHORT; len = 3'd2; end
        8'hE9: begin kind = K_NEAR;  len = 3'd3; end
        8'hEA: begin kind = K_FAR;   len = 3'd5; end
        8'hE3: begin kind = K_JCXZ;  len = 3'd2; end
        8'hE2: begin kind = K_LOOP;  len = 3'd2; lmode = LM_PLAIN; end
        8'hE1: begin kind = K_LOOP;  len = 3'd2; lmode = LM_ZSET;  end
        8'hE0: begin kind = K_LOOP;  len = 3'd2; lmode = LM_ZCLR;  end
        default: begin kind = K_NONE; len = 3'd0; end
      endcase
    end
  end
endmodule

// File: rtl/xfer_cond.sv
module xfer_cond
  import xfer_pkg::*;
(
  input  logic [3:0] sel,
  input  flags_t     fl,
  output logic       hit
);
  localparam int NCOND = 8;
  logic [NCOND-1:0] base;
  logic             sgn_ne;

  always_comb begin
    sgn_ne  = fl.s ^ fl.o;
    base[0] = fl.o;
    base[1] = fl.c;
    base[2] = fl.z;
    base[3] = fl.c | fl.z;
    base[4] = fl.s;
    base[5] = fl.p;
    base[6] = sgn_ne;
    base[7] = fl.z | sgn_ne;
    hit     = base[sel[3:1]] ^ sel[0];
  end
endmodule

// File: rtl/xfer_addr.sv
module xfer_addr #(
  parameter int IP_W = 16
) (
  input  logic [IP_W-1:0] ip,
  input  logic [2:0]      len,
  input  logic [IP_W-1:0] disp,
  output logic [IP_W-1:0] fall,
  output logic [IP_W-1:0] target
);
  always_comb begin
    fall   = ip + IP_W'(len);
    target = fall + disp;
  end
endmodule

// File: rtl/ctl_xfer_unit.sv
module ctl_xfer_unit
  import xfer_pkg::*;
#(
  parameter int IP_W  = 16,
  parameter int SEG_W = 16,
  parameter int CX_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_op,
  input  logic [IP_W+SEG_W-1:0] in_imm,
  input  logic [IP_W-1:0]    in_ip,
  input  logic [SEG_W-1:0]   in_cs,
  input  logic [CX_W-1:0]    in_cx,
  input  logic               flag_c,
  input  logic               flag_p,
  input  logic               flag_z,
  input  logic               flag_s,
  input  logic               flag_o,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_taken,
  output logic [IP_W-1:0]    out_ip,
  output logic [SEG_W-1:0]   out_cs,
  output logic               out_cx_we,
  output logic [CX_W-1:0]    out_cx
);
  kind_t            kind;
  loop_mode_t       lmode;
  logic [2:0]       len;
  logic             cond_hit;
  flags_t           fl;
  logic [IP_W-1:0]  disp, fall, target;
  logic [CX_W-1:0]  cx_dec;
  logic             take;
  logic [IP_W-1:0]  nip;
  logic [SEG_W-1:0] ncs;
  logic             ncx_we;
  logic [CX_W-1:0]  ncx;
  logic             fire;

  assign fl = '{o: flag_o, s: flag_s, z: flag_z, p: flag_p, c: flag_c};

  xfer_decode u_dec (.op(in_op), .kind(kind), .len(len), .lmode(lmode));
  xfer_cond   u_cond (.sel(in_op[3:0]), .fl(fl), .hit(cond_hit));
  xfer_addr #(.IP_W(IP_W)) u_addr (
    .ip(in_ip), .len(len), .disp(disp), .fall(fall), .target(target)
  );

  always_comb begin
    if (kind == K_NEAR) disp = IP_W'($signed(in_imm[15:0]));
    else                disp = IP_W'($signed(in_imm[7:0]));
  end

  always_comb begin
    cx_dec = in_cx - 1'b1;
    take   = 1'b0;
    ncx_we = 1'b0;
    unique case (kind)
      K_JCC:   take = cond_hit;
      K_SHORT, K_NEAR, K_FAR: take = 1'b1;
      K_JCXZ:  take = (in_cx == '0);
      K_LOOP: begin
        ncx_we = 1'b1;
        case (lmode)
          LM_ZSET: take = (cx_dec != '0) &&  flag_z;
          LM_ZCLR: take = (cx_dec != '0) && !flag_z;
          default: take = (cx_dec != '0);
        endcase
      end
      default: take = 1'b0;
    endcase
    if (kind == K_FAR)       nip = in_imm[IP_W-1:0];
    else if (take)           nip = target;
    else if (kind == K_NONE) nip = in_ip;
    else                     nip = fall;
    ncs = (kind == K_FAR) ? in_imm[IP_W +: SEG_W] : in_cs;
    ncx = ncx_we ? cx_dec : in_cx;
  end

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_taken <= 1'b0;
      out_ip    <= '0;
      out_cs    <= '0;
      out_cx_we <= 1'b0;
      out_cx    <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_taken <= take;
        out_ip    <= nip;
        out_cs    <= ncs;
        out_cx_we <= ncx_we;
        out_cx    <= ncx;
      end
    end
  end

  // Stream rules
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_ip) && $stable(out_cs)
      && $stable(out_cx) && $stable(out_taken) && $stable(out_cx_we));
  // Segment kept by all but the far form
  assert_cs_keep_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op != 8'hEA |=> out_cs == $past(in_cs));
  assert_far_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 8'hEA |=> out_taken && out_ip == $past(in_imm[IP_W-1:0])
      && out_cs == $past(in_imm[IP_W +: SEG_W]));
  assert_cxz_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 8'hE3 |=> !out_cx_we && (out_taken == ($past(in_cx) == '0)));
  assert_loop_cx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (in_op == 8'hE0 || in_op == 8'hE1 || in_op == 8'hE2)
      |=> out_cx_we && out_cx == CX_W'($past(in_cx) - 1'b1));
endmodule

// File: tb/ctl_xfer_unit_test.sv
module ctl_xfer_unit_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [7:0]  in_op = 0;
  logic [31:0] in_imm = 0;
  logic [15:0] in_ip = 0, in_cs = 0, in_cx = 0;
  logic        flag_c = 0, flag_p = 0, flag_z = 0, flag_s = 0, flag_o = 0;
  logic        out_valid, out_ready = 0, out_taken, out_cx_we;
  logic [15:0] out_ip, out_cs, out_cx;

  always #4 clk = ~clk;

  ctl_xfer_unit uut (.*);

  typedef struct {
    logic [7:0] op; logic [31:0] imm; logic [15:0] ip, cs, cx;
    logic c, p, z, s, o;
  } stim_t;
  typedef struct {
    logic taken; logic [15:0] ip, cs, cx; logic we; string tag;
  } res_t;

  stim_t stim_q[$];
  res_t  exp_q[$];
  stim_t cur;
  int total = 0, bad = 0;
  bit finished = 0;

  function automatic res_t model(stim_t s);
    res_t r;
    logic [15:0] d8, nxt;
    logic t;
    logic [15:0] dec;
    d8  = {{8{s.imm[7]}}, s.imm[7:0]};
    dec = s.cx - 16'd1;
    r.cs = s.cs; r.cx = s.cx; r.we = 0; t = 0;
    nxt = s.ip + 16'd2;
    if (s.op >= 8'h70 && s.op <= 8'h7F) begin
      case (s.op)
        8'h70: t = s.o;            8'h71: t = !s.o;
        8'h72: t = s.c;            8'h73: t = !s.c;
        8'h74: t = s.z;            8'h75: t = !s.z;
        8'h76: t = s.c || s.z;     8'h77: t = !s.c && !s.z;
        8'h78: t = s.s;            8'h79: t = !s.s;
        8'h7A: t = s.p;            8'h7B: t = !s.p;
        8'h7C: t = s.s != s.o;     8'h7D: t = s.s == s.o;
        8'h7E: t = s.z || (s.s != s.o);
        default: t = !s.z && (s.s == s.o);
      endcase
      r.tag = "R6 R7";
      r.ip  = t ? nxt + d8 : nxt;
    end else begin
      case (s.op)
        8'hEB: begin t = 1; r.ip = nxt + d8; r.tag = "R3"; end
        8'hE9: begin t = 1; r.ip = s.ip + 16'd3 + s.imm[15:0]; r.tag = "R4"; end
        8'hEA: begin t = 1; r.ip = s.imm[15:0]; r.cs = s.imm[31:16]; r.tag = "R5"; end
        8'hE3: begin t = (s.cx == 0); r.ip = t ? nxt + d8 : nxt; r.tag = "R8"; end
        8'hE2: begin t = dec != 0; r.we = 1; r.cx = dec;
                     r.ip = t ? nxt + d8 : nxt; r.tag = "R9"; end
        8'hE1: begin t = dec != 0 && s.z; r.we = 1; r.cx = dec;
                     r.ip = t ? nxt + d8 : nxt; r.tag = "R10"; end
        8'hE0: begin t = dec != 0 && !s.z; r.we = 1; r.cx = dec;
                     r.ip = t ? nxt + d8 : nxt; r.tag = "R10"; end
        default: begin t = 0; r.ip = s.ip; r.tag = "R11"; end
      endcase
    end
    r.taken = t;
    return r;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic add(logic [7:0] op, logic [31:0] imm, logic [15:0] ip,
                     logic [15:0] cx, logic [4:0] f);
    stim_t s;
    s.op = op; s.imm = imm; s.ip = ip; s.cs = 16'h1234; s.cx = cx;
    {s.o, s.s, s.z, s.p, s.c} = f;
    stim_q.push_back(s);
  endtask

  function automatic logic [7:0] pick_op();
    int k = $urandom_range(0, 24);
    logic [7:0] x;
    if (k < 16) return 8'h70 + 8'(k);
    case (k)
      16: return 8'hEB; 17: return 8'hE9; 18: return 8'hEA; 19: return 8'hE3;
      20: return 8'hE2; 21: return 8'hE1; 22: return 8'hE0;
      default: begin
        x = 8'($urandom);
        while (x[7:4] == 4'h7 || (x >= 8'hE0 && x <= 8'hE3) || x == 8'hE9
               || x == 8'hEA || x == 8'hEB) x = 8'($urandom);
        return x;
      end
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit stall = 0;
    logic [15:0] h_ip, h_cs, h_cx;
    logic h_t, h_we;
    res_t e;
    int cyc = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1", "out_valid", out_valid, 0);
    chk(in_ready == 1, "R1", "in_ready", in_ready, 1);
    rst_n = 1;

    // Directed corners (flags {o,s,z,p,c})
    add(8'hEB, 32'h80, 16'h0010, 0, 0);        // R3 wrap backwards
    add(8'hEB, 32'h7F, 16'hFFF0, 0, 0);        // R3 wrap forwards
    add(8'hE9, 32'h0005, 16'hFFFE, 0, 0);      // R4 wrap
    add(8'hE9, 32'h8000, 16'h1000, 0, 0);      // R4 negative
    add(8'hEA, 32'hBEEF_0102, 16'h0100, 0, 0); // R5
    add(8'hE3, 32'h04, 16'h0200, 16'h0000, 0); // R8 taken
    add(8'hE3, 32'h04, 16'h0200, 16'h0001, 0); // R8 not taken
    add(8'hE2, 32'hFC, 16'h0300, 16'h0001, 0); // R9 reaches zero
    add(8'hE2, 32'hFC, 16'h0300, 16'h0000, 0); // R9 wraps to FFFF
    add(8'hE1, 32'h10, 16'h0400, 16'h0005, 5'b00100); // R10 taken
    add(8'hE1, 32'h10, 16'h0400, 16'h0005, 5'b00000); // R10 not taken
    add(8'hE0, 32'h10, 16'h0400, 16'h0005, 5'b00100); // R10 not taken
    add(8'hE0, 32'h10, 16'h0400, 16'h0001, 5'b00000); // R10 count ends
    add(8'h90, 32'h10, 16'h0500, 16'h0007, 5'b11111); // R11
    for (int op = 8'h70; op <= 8'h7F; op++)
      for (int f = 0; f < 32; f++)
        add(8'(op), 32'h06, 16'h0600, 16'h0003, 5'(f)); // R6 R7
    for (int i = 0; i < 1500; i++) begin
      stim_t s;
      s.op = pick_op(); s.imm = $urandom; s.ip = 16'($urandom);
      s.cs = 16'($urandom);
      case ($urandom_range(0, 3))
        0: s.cx = 0; 1: s.cx = 1; 2: s.cx = 2; default: s.cx = 16'($urandom);
      endcase
      {s.o, s.s, s.z, s.p, s.c} = 5'($urandom);
      stim_q.push_back(s);
    end

    while ((stim_q.size() > 0 || exp_q.size() > 0 || in_valid) && cyc < 150000) begin
      @(negedge clk);
      cyc++;
      if (stall) begin
        chk(out_valid && out_ip == h_ip && out_cs == h_cs && out_cx == h_cx
            && out_taken == h_t && out_we_eq(h_we), "R2", "held result",
            out_ip, h_ip);
      end
      if (!in_valid || in_ready) begin
        if (stim_q.size() > 0 && $urandom_range(0, 4) != 0) begin
          cur = stim_q.pop_front();
          in_valid = 1; in_op = cur.op; in_imm = cur.imm; in_ip = cur.ip;
          in_cs = cur.cs; in_cx = cur.cx;
          flag_c = cur.c; flag_p = cur.p; flag_z = cur.z; flag_s = cur.s; flag_o = cur.o;
        end else in_valid = 0;
      end
      out_ready = ($urandom_range(0, 3) != 0);
      #1;
      chk(in_ready == (!out_valid || out_ready), "R2", "in_ready", in_ready,
          !out_valid || out_ready);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(0, "R2", "unexpected result", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk(out_taken == e.taken, e.tag, "taken", out_taken, e.taken);
          chk(out_ip == e.ip, e.tag, "next ip", out_ip, e.ip);
          chk(out_cs == e.cs, (e.tag == "R5") ? "R5" : "R12", "next cs", out_cs, e.cs);
          chk(out_cx_we == e.we, (e.we) ? e.tag : "R12", "cx write", out_cx_we, e.we);
          chk(out_cx == e.cx, (e.we) ? e.tag : "R12", "cx value", out_cx, e.cx);
        end
      end
      stall = out_valid && !out_ready;
      h_ip = out_ip; h_cs = out_cs; h_cx = out_cx; h_t = out_taken; h_we = out_cx_we;
      if (in_valid && in_ready) exp_q.push_back(model(cur));
    end
    chk(exp_q.size() == 0 && stim_q.size() == 0, "R2", "drained", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic bit out_we_eq(logic v);
    return out_cx_we == v;
  endfunction
endmodule